// File: doc/BRIEF.md
# Fetch-Side Branch Predictor

This block sits beside the fetch stage of a small in-order core and guesses, for each fetch address it is offered, whether a branch there will be taken and where it will go. Direction comes from a two-level adaptive scheme. A global history register of recent conditional outcomes is combined by XOR with fetch-address bits to pick a 2-bit saturating counter. Targets come from a small set-associative target buffer with tree pseudo-LRU replacement. Return targets come from a circular return-address stack. No separate loop or indirect-jump predictor is present.

Requests are accepted at most once every two cycles, and each result appears one cycle after acceptance. Every result carries a checkpoint of the history register as it was before that prediction. The back end sends resolved branches through the update port. A resolution marked as a misprediction restores the history from the checkpoint it returns and holds off new requests for a long redirect window. A resolution that reports a correct direction but a missing target holds off requests for a shorter window.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset `pred_ready` is 1, `pred_valid` is 0, the history register is zero, every direction counter holds weakly not-taken (value 1), and the target buffer and return stack are empty.
- R2: A request is accepted when `pred_req` and `pred_ready` are both 1. `pred_valid` is 1 for exactly the one cycle after acceptance, and `pred_ready` is 0 in that cycle, so at most one prediction is made every two cycles.
- R3: A fetch address that misses the target buffer is predicted not taken, with target equal to the address plus 4.
- R4: A conditional branch that hits the target buffer uses the counter at index history XOR address bits [13:2]. It is predicted taken when that counter is 2 or 3. Each conditional update moves the counter at index `upd_hist` XOR `upd_pc`[13:2] one step toward the outcome, saturating at 0 and 3.
- R5: `pred_hist` returns the history as it was before the prediction. A conditional target-buffer hit shifts its predicted direction into bit 0 of the history. A mispredict update loads `upd_hist`, shifted left by one with `upd_taken` in bit 0 when the kind is conditional and unchanged otherwise.
- R6: The target buffer has 32 sets of 4 ways, with the set selected by address bits [6:2]. It allocates or rewrites an entry only on updates with `upd_taken` = 1. Tree pseudo-LRU replacement, touched by updates, fills the ways of a set in the order 0, 2, 1, 3 from reset and then evicts way 0.
- R7: The branch kind code is 0 conditional, 1 jump, 2 call, 3 return. Jump and call hits are always predicted taken to the stored target, and a call hit pushes its address plus 4 onto the return stack.
- R8: A return hit is predicted taken to the top of the return stack and pops it. If the stack is empty it uses the stored target instead. The stack holds 8 entries, and a push when full overwrites the oldest.
- R9: An update with `upd_mispred` = 1 holds `pred_ready` at 0 for exactly 13 cycles after the update edge.
- R10: An update with `upd_tgt_miss` = 1 and no misprediction holds `pred_ready` at 0 for exactly 7 cycles after the update edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | 32 | Fetch address to predict |
| pred_ready | output | 1 | Request can be accepted this cycle |
| pred_valid | output | 1 | Prediction result strobe |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted next fetch address |
| pred_hist | output | 12 | History checkpoint taken before this prediction |
| upd_valid | input | 1 | Resolution update strobe |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_kind | input | 2 | Branch kind code (0 cond, 1 jump, 2 call, 3 return) |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | 32 | Resolved target |
| upd_hist | input | 12 | History checkpoint returned with the resolution |
| upd_mispred | input | 1 | Resolution was mispredicted; restore history and apply long stall |
| upd_tgt_miss | input | 1 | Direction correct but target was absent; apply short stall |

## Verification
The assertions assume that `pred_req` stays low during reset. They also assume that a mispredicting update never arrives in the same cycle as an accepted request, since the update takes priority over the speculative history shift. The stimulus issues requests and updates from separate tasks that never overlap, so both assumptions hold. Every `upd_hist` value is chosen by the bench, so the counter index the bench expects for training and lookup is always known.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef enum logic [1:0] {
      BK_COND = 2'd0,
      BK_JUMP = 2'd1,
      BK_CALL = 2'd2,
      BK_RET  = 2'd3
   } br_kind_e;

   localparam int unsigned CTR_W    = 2;
   localparam logic [1:0]  CTR_INIT = 2'b01;
   localparam logic [1:0]  CTR_MAX  = 2'b11;

endpackage

// File: rtl/bp_pht.sv
module bp_pht #(
   parameter int unsigned HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_idx,
   input  logic              wr_taken
);
   import bp_pkg::*;

   localparam int unsigned ENTRIES = 1 << HIST_W;

   logic [CTR_W-1:0] ctr [ENTRIES];
   logic [CTR_W-1:0] cur;

   assign rd_taken = ctr[rd_idx][CTR_W-1];
   assign cur      = ctr[wr_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_INIT;
      end else if (wr_en) begin
         if (wr_taken && cur != CTR_MAX)  ctr[wr_idx] <= cur + 1'b1;
         else if (!wr_taken && cur != '0) ctr[wr_idx] <= cur - 1'b1;
      end
   end

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SETS   = 32,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned ALIGN  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_pc,
   output logic              lk_hit,
   output logic [ADDR_W-1:0] lk_target,
   output logic [1:0]        lk_kind,
   input  logic              up_en,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic [ADDR_W-1:0] up_target,
   input  logic [1:0]        up_kind
);
   localparam int unsigned SET_W = $clog2(SETS);
   localparam int unsigned WAY_W = $clog2(WAYS);
   localparam int unsigned TAG_W = ADDR_W - SET_W - ALIGN;

   logic              vld  [SETS][WAYS];
   logic [TAG_W-1:0]  tag  [SETS][WAYS];
   logic [ADDR_W-1:0] tgt  [SETS][WAYS];
   logic [1:0]        knd  [SETS][WAYS];
   logic [WAYS-1:0]   plru [SETS];

   logic [SET_W-1:0] lk_set, up_set;
   logic [TAG_W-1:0] lk_tag, up_tag;
   logic [WAYS-1:0]  lk_match, up_match;
   logic [WAY_W-1:0] lk_way, up_hit_way, up_way;
   logic             up_hit;
   logic             lk_unused, up_unused;

   assign lk_set    = lk_pc[ALIGN +: SET_W];
   assign lk_tag    = lk_pc[ADDR_W-1 -: TAG_W];
   assign up_set    = up_pc[ALIGN +: SET_W];
   assign up_tag    = up_pc[ADDR_W-1 -: TAG_W];
   assign lk_unused = ^lk_pc[ALIGN-1:0];
   assign up_unused = ^up_pc[ALIGN-1:0];

   // Tree pseudo-LRU, heap numbered from node 1; bit 0 of each vector is spare.
   function automatic logic [WAY_W-1:0] plru_victim(input logic [WAYS-1:0] b);
      logic [WAY_W:0] n;
      n = {{WAY_W{1'b0}}, 1'b1};
      for (int l = 0; l < WAY_W; l++) n = {n[WAY_W-1:0], b[n[WAY_W-1:0]]};
      return n[WAY_W-1:0];
   endfunction

   function automatic logic [WAYS-1:0] plru_touch(input logic [WAYS-1:0] b,
                                                  input logic [WAY_W-1:0] w);
      logic [WAYS-1:0]  r;
      logic [WAY_W:0]   n;
      logic [WAY_W-1:0] ws;
      r  = b;
      n  = {{WAY_W{1'b0}}, 1'b1};
      ws = w;
      for (int l = 0; l < WAY_W; l++) begin
         r[n[WAY_W-1:0]] = ~ws[WAY_W-1];
         n  = {n[WAY_W-1:0], ws[WAY_W-1]};
         ws = ws << 1;
      end
      return r;
   endfunction

   for (genvar w = 0; w < WAYS; w++) begin : g_way_cmp
      assign lk_match[w] = vld[lk_set][w] && (tag[lk_set][w] == lk_tag);
      assign up_match[w] = vld[up_set][w] && (tag[up_set][w] == up_tag);
   end

   always_comb begin
      lk_way     = '0;
      up_hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_match[w]) lk_way     = WAY_W'(w);
         if (up_match[w]) up_hit_way = WAY_W'(w);
      end
   end

   assign lk_hit    = |lk_match;
   assign lk_target = tgt[lk_set][lk_way];
   assign lk_kind   = knd[lk_set][lk_way];
   assign up_hit    = |up_match;
   assign up_way    = up_hit ? up_hit_way : plru_victim(plru[up_set]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            plru[s] <= '0;
            for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
         end
      end else if (up_en) begin
         vld[up_set][up_way] <= 1'b1;
         tag[up_set][up_way] <= up_tag;
         tgt[up_set][up_way] <= up_target;
         knd[up_set][up_way] <= up_kind;
         plru[up_set]        <= plru_touch(plru[up_set], up_way);
      end
   end

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic              top_valid,
   output logic [ADDR_W-1:0] top_addr
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [ADDR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic [PTR_W-1:0]  top_ptr;
   logic [CNT_W-1:0]  fill;

   assign top_ptr   = wr_ptr - 1'b1;
   assign top_valid = (fill != '0);
   assign top_addr  = mem[top_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         fill   <= '0;
      end else if (push) begin
         // Circular: a push into a full stack drops the oldest entry.
         mem[wr_ptr] <= push_addr;
         wr_ptr      <= wr_ptr + 1'b1;
         if (fill != CNT_W'(DEPTH)) fill <= fill + 1'b1;
      end else if (pop && top_valid) begin
         wr_ptr <= top_ptr;
         fill   <= fill - 1'b1;
      end
   end

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned HIST_W       = 12,
   parameter int unsigned BTB_SETS     = 32,
   parameter int unsigned BTB_WAYS     = 4,
   parameter int unsigned RAS_DEPTH    = 8,
   parameter int unsigned INSTR_BYTES  = 4,
   parameter int unsigned MISS_PENALTY = 13,
   parameter int unsigned TGT_PENALTY  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_req,
   input  logic [ADDR_W-1:0] pred_pc,
   output logic              pred_ready,
   output logic              pred_valid,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_target,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [1:0]        upd_kind,
   input  logic              upd_taken,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              upd_mispred,
   input  logic              upd_tgt_miss
);
   import bp_pkg::*;

   localparam int unsigned ALIGN     = $clog2(INSTR_BYTES);
   localparam int unsigned STALL_MAX = (MISS_PENALTY > TGT_PENALTY) ? MISS_PENALTY : TGT_PENALTY;
   localparam int unsigned STALL_W   = $clog2(STALL_MAX + 1);

   // Elaboration-time parameter checks
   if (INSTR_BYTES < 2 || (1 << ALIGN) != INSTR_BYTES)
      $error("INSTR_BYTES must be a power of two of at least 2");
   if (BTB_WAYS < 2 || (1 << $clog2(BTB_WAYS)) != BTB_WAYS)
      $error("BTB_WAYS must be a power of two of at least 2");
   if (BTB_SETS < 2 || (1 << $clog2(BTB_SETS)) != BTB_SETS)
      $error("BTB_SETS must be a power of two of at least 2");
   if (RAS_DEPTH < 2 || (1 << $clog2(RAS_DEPTH)) != RAS_DEPTH)
      $error("RAS_DEPTH must be a power of two of at least 2");
   if (HIST_W < 2 || ADDR_W < HIST_W + ALIGN || ADDR_W <= $clog2(BTB_SETS) + ALIGN)
      $error("address too narrow for history or target-buffer indexing");
   if (MISS_PENALTY < 1 || TGT_PENALTY < 1)
      $error("penalties must be at least one cycle");

   logic              accept;
   logic              gap_q;
   logic [STALL_W-1:0] stall_q;
   logic [HIST_W-1:0] ghist_q;

   logic              dir_taken;
   logic              btb_hit;
   logic [ADDR_W-1:0] btb_target;
   logic [1:0]        btb_kind;
   br_kind_e          hit_kind;
   logic              ras_valid;
   logic [ADDR_W-1:0] ras_top;

   logic              nxt_taken;
   logic [ADDR_W-1:0] nxt_target;
   logic              ras_push, ras_pop, is_cond;
   logic [ADDR_W-1:0] fall_through;

   assign pred_ready   = !gap_q && (stall_q == '0);
   assign accept       = pred_req && pred_ready;
   assign fall_through = pred_pc + ADDR_W'(INSTR_BYTES);
   assign hit_kind     = br_kind_e'(btb_kind);

   bp_pht #(.HIST_W(HIST_W)) pht_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (ghist_q ^ pred_pc[ALIGN +: HIST_W]),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid && (upd_kind == BK_COND)),
      .wr_idx   (upd_hist ^ upd_pc[ALIGN +: HIST_W]),
      .wr_taken (upd_taken)
   );

   bp_btb #(
      .ADDR_W (ADDR_W),
      .SETS   (BTB_SETS),
      .WAYS   (BTB_WAYS),
      .ALIGN  (ALIGN)
   ) btb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_pc     (pred_pc),
      .lk_hit    (btb_hit),
      .lk_target (btb_target),
      .lk_kind   (btb_kind),
      .up_en     (upd_valid && upd_taken),
      .up_pc     (upd_pc),
      .up_target (upd_target),
      .up_kind   (upd_kind)
   );

   bp_ras #(
      .ADDR_W (ADDR_W),
      .DEPTH  (RAS_DEPTH)
   ) ras_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ras_push),
      .push_addr (fall_through),
      .pop       (ras_pop),
      .top_valid (ras_valid),
      .top_addr  (ras_top)
   );

   always_comb begin
      nxt_taken  = 1'b0;
      nxt_target = fall_through;
      ras_push   = 1'b0;
      ras_pop    = 1'b0;
      is_cond    = 1'b0;
      if (btb_hit) begin
         unique case (hit_kind)
            BK_COND: begin
               is_cond   = 1'b1;
               nxt_taken = dir_taken;
               if (dir_taken) nxt_target = btb_target;
            end
            BK_JUMP: begin
               nxt_taken  = 1'b1;
               nxt_target = btb_target;
            end
            BK_CALL: begin
               nxt_taken  = 1'b1;
               nxt_target = btb_target;
               ras_push   = accept;
            end
            BK_RET: begin
               nxt_taken = 1'b1;
               if (ras_valid) begin
                  nxt_target = ras_top;
                  ras_pop    = accept;
               end else begin
                  nxt_target = btb_target;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q       <= 1'b0;
         stall_q     <= '0;
         ghist_q     <= '0;
         pred_valid  <= 1'b0;
         pred_taken  <= 1'b0;
         pred_target <= '0;
         pred_hist   <= '0;
      end else begin
         gap_q      <= accept;
         pred_valid <= accept;
         if (accept) begin
            pred_taken  <= nxt_taken;
            pred_target <= nxt_target;
            pred_hist   <= ghist_q;
         end

         if (upd_valid && upd_mispred) begin
            if (upd_kind == BK_COND) ghist_q <= {upd_hist[HIST_W-2:0], upd_taken};
            else                     ghist_q <= upd_hist;
         end else if (accept && is_cond) begin
            ghist_q <= {ghist_q[HIST_W-2:0], nxt_taken};
         end

         if (upd_valid && upd_mispred)       stall_q <= STALL_W'(MISS_PENALTY);
         else if (upd_valid && upd_tgt_miss) stall_q <= STALL_W'(TGT_PENALTY);
         else if (stall_q != '0)             stall_q <= stall_q - 1'b1;
      end
   end

endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned INSTR_BYTES  = 4,
   parameter int unsigned MISS_PENALTY = 13,
   parameter int unsigned TGT_PENALTY  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pred_req,
   input logic [ADDR_W-1:0] pred_pc,
   input logic              pred_ready,
   input logic              pred_valid,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_target,
   input logic              upd_valid,
   input logic              upd_mispred,
   input logic              upd_tgt_miss
);
   logic [7:0] miss_win, tgt_win;

   // Independent window counters for the two penalty holds.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         miss_win <= '0;
         tgt_win  <= '0;
      end else begin
         if (upd_valid && upd_mispred)  miss_win <= 8'(MISS_PENALTY);
         else if (miss_win != '0)       miss_win <= miss_win - 1'b1;
         if (upd_valid && upd_tgt_miss) tgt_win  <= 8'(TGT_PENALTY);
         else if (tgt_win != '0)        tgt_win  <= tgt_win - 1'b1;
      end
   end

   a_r2_one_per_two: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_req && pred_ready) |=> (pred_valid && !pred_ready));

   a_r2_valid_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(pred_req && pred_ready));

   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |=> !pred_valid);

   a_r3_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !pred_taken) |-> (pred_target == $past(pred_pc) + ADDR_W'(INSTR_BYTES)));

   a_r9_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_win != '0) |-> !pred_ready);

   a_r10_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_win != '0) |-> !pred_ready);

endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk #(
   .ADDR_W       (ADDR_W),
   .INSTR_BYTES  (INSTR_BYTES),
   .MISS_PENALTY (MISS_PENALTY),
   .TGT_PENALTY  (TGT_PENALTY)
) chk_i (.*);

// File: tb/bp_fetch_predictor_tb_top.sv
`timescale 1ns/1ps
module bp_fetch_predictor_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_req = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_ready, pred_valid, pred_taken;
   logic [31:0] pred_target;
   logic [11:0] pred_hist;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [1:0]  upd_kind = '0;
   logic        upd_taken = 1'b0;
   logic [31:0] upd_target = '0;
   logic [11:0] upd_hist = '0;
   logic        upd_mispred = 1'b0;
   logic        upd_tgt_miss = 1'b0;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bp_fetch_predictor dut_i (
      .clk, .rst_n, .pred_req, .pred_pc, .pred_ready, .pred_valid,
      .pred_taken, .pred_target, .pred_hist, .upd_valid, .upd_pc,
      .upd_kind, .upd_taken, .upd_target, .upd_hist, .upd_mispred,
      .upd_tgt_miss
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_predict(input logic [31:0] pc);
      @(negedge clk);
      while (!pred_ready) @(negedge clk);
      pred_req = 1'b1;
      pred_pc  = pc;
      @(negedge clk);
      pred_req = 1'b0;
   endtask

   task automatic do_update(input logic [31:0] pc, input logic [1:0] kind,
                            input logic tk, input logic [31:0] tgt,
                            input logic [11:0] h, input logic mis,
                            input logic tmiss);
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_kind = kind; upd_taken = tk;
      upd_target = tgt; upd_hist = h; upd_mispred = mis; upd_tgt_miss = tmiss;
      @(negedge clk);
      upd_valid = 1'b0; upd_mispred = 1'b0; upd_tgt_miss = 1'b0;
   endtask

   task automatic count_hold(output int n);
      n = 0;
      while (!pred_ready) begin
         n++;
         @(negedge clk);
      end
   endtask

   // Loads the history register through a jump-kind mispredict with no allocation.
   task automatic set_hist(input logic [11:0] h);
      do_update(32'h0000_0F00, 2'd1, 1'b0, 32'h0, h, 1'b1, 1'b0);
   endtask

   function automatic logic [11:0] pidx(input logic [31:0] pc);
      return pc[13:2];
   endfunction

   localparam logic [31:0] PA  = 32'h0000_0500;
   localparam logic [31:0] PC1 = 32'h0000_0104;
   localparam logic [31:0] PC2 = 32'h0000_0208;
   localparam logic [31:0] RET = 32'h0000_3040;

   initial begin : main
      int n;
      int ctr;
      bit outc [9];
      logic [11:0] h0;
      outc = '{0, 0, 0, 1, 1, 1, 1, 0, 0};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", 32'(pred_ready), 32'd1);
      chk("R1", "valid after reset", 32'(pred_valid), 32'd0);

      // R2/R3: miss on empty target buffer
      do_predict(PA);
      chk("R2", "valid one cycle after accept", 32'(pred_valid), 32'd1);
      chk("R2", "ready low in result cycle", 32'(pred_ready), 32'd0);
      chk("R3", "miss not taken", 32'(pred_taken), 32'd0);
      chk("R3", "miss target", pred_target, PA + 32'd4);
      chk("R1", "history zero at reset", 32'(pred_hist), 32'd0);
      @(negedge clk);
      chk("R2", "valid is a single pulse", 32'(pred_valid), 32'd0);
      chk("R2", "ready back after one gap", 32'(pred_ready), 32'd1);

      // R4/R5: train one counter then look it up
      do_update(PC1, 2'd0, 1'b1, 32'h0000_0800, 12'h000, 1'b0, 1'b0);
      do_predict(PC1);
      chk("R4", "trained counter taken", 32'(pred_taken), 32'd1);
      chk("R4", "taken target", pred_target, 32'h0000_0800);
      do_predict(PC1);
      chk("R4", "untrained index weakly not-taken", 32'(pred_taken), 32'd0);
      chk("R4", "not-taken target", pred_target, PC1 + 32'd4);
      chk("R5", "history shifted by taken cond", 32'(pred_hist), 32'h1);

      // R9: mispredict hold; R5 restored history seen as checkpoint
      set_hist(12'h0A5);
      count_hold(n);
      chk("R9", "mispredict hold cycles", 32'(n), 32'd13);
      do_predict(PC1);
      chk("R5", "restored history checkpoint", 32'(pred_hist), 32'h0A5);
      chk("R4", "history XOR selects other counter", 32'(pred_taken), 32'd0);

      // R4: saturating counter sweep at one index
      h0 = 12'h0A5;
      do_update(PC2, 2'd0, 1'b1, 32'h0000_0900, 12'h300, 1'b0, 1'b0);
      ctr = 1;
      for (int i = 0; i < 9; i++) begin
         do_update(PC2, 2'd0, outc[i], 32'h0000_0900, h0, 1'b0, 1'b0);
         if (outc[i] && ctr < 3) ctr++;
         else if (!outc[i] && ctr > 0) ctr--;
         set_hist(h0);
         do_predict(PC2);
         chk("R4", $sformatf("sweep step %0d direction", i), 32'(pred_taken),
             32'(ctr >= 2));
         chk("R4", $sformatf("sweep step %0d target", i), pred_target,
             (ctr >= 2) ? 32'h0000_0900 : PC2 + 32'd4);
      end
      if ((pidx(PC2) ^ h0) == (pidx(PC2) ^ 12'h300))
         chk("R4", "sweep indices distinct", 32'd0, 32'd1);

      // R5: conditional mispredict appends the resolved direction
      do_update(PC2, 2'd0, 1'b1, 32'h0000_0900, 12'h7FF, 1'b1, 1'b0);
      do_predict(PA);
      chk("R5", "cond restore appends outcome", 32'(pred_hist), 32'hFFF);

      // R10: target-miss hold
      do_update(32'h0000_0F04, 2'd1, 1'b0, 32'h0, 12'h0, 1'b0, 1'b1);
      count_hold(n);
      chk("R10", "target-miss hold cycles", 32'(n), 32'd7);

      // R6: no allocation on a not-taken update
      do_update(32'h0000_0600, 2'd1, 1'b0, 32'h0000_0ABC, 12'h0, 1'b0, 1'b0);
      do_predict(32'h0000_0600);
      chk("R6", "not-taken update leaves no entry", 32'(pred_taken), 32'd0);

      // R6/R7: five jumps into set 20, pseudo-LRU evicts the first
      for (int k = 0; k < 5; k++)
         do_update(32'h0000_4050 + 32'(k) * 32'h80, 2'd1, 1'b1,
                   32'h0000_7000 + 32'(k) * 32'h10, 12'h0, 1'b0, 1'b0);
      do_predict(32'h0000_4050);
      chk("R6", "first way evicted", 32'(pred_taken), 32'd0);
      for (int k = 1; k < 5; k++) begin
         do_predict(32'h0000_4050 + 32'(k) * 32'h80);
         chk("R7", $sformatf("jump %0d taken", k), 32'(pred_taken), 32'd1);
         chk("R6", $sformatf("jump %0d target", k), pred_target,
             32'h0000_7000 + 32'(k) * 32'h10);
      end
      do_update(32'h0000_4150, 2'd1, 1'b1, 32'h0000_7777, 12'h0, 1'b0, 1'b0);
      do_predict(32'h0000_4150);
      chk("R6", "taken hit rewrites target", pred_target, 32'h0000_7777);

      // R7/R8: calls and returns
      for (int k = 0; k < 9; k++)
         do_update(32'h0000_2000 + 32'(k) * 4, 2'd2, 1'b1,
                   32'h0000_6000 + 32'(k) * 32'h100, 12'h0, 1'b0, 1'b0);
      do_update(RET, 2'd3, 1'b1, 32'h0000_5554, 12'h0, 1'b0, 1'b0);
      do_predict(32'h0000_2000);
      chk("R7", "call taken", 32'(pred_taken), 32'd1);
      chk("R7", "call target", pred_target, 32'h0000_6000);
      do_predict(RET);
      chk("R8", "return uses stack", pred_target, 32'h0000_2004);
      do_predict(RET);
      chk("R8", "empty stack falls back", pred_target, 32'h0000_5554);
      chk("R8", "return taken on fallback", 32'(pred_taken), 32'd1);
      for (int k = 0; k < 9; k++) do_predict(32'h0000_2000 + 32'(k) * 4);
      for (int k = 8; k >= 1; k--) begin
         do_predict(RET);
         chk("R8", $sformatf("overflow pop %0d", k), pred_target,
             32'h0000_2000 + 32'(k) * 4 + 32'd4);
      end
      do_predict(RET);
      chk("R8", "oldest overwritten on overflow", pred_target, 32'h0000_5554);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule